// File: doc/BRIEF.md
# Show-ahead synchronous FIFO, four words deep

This block is a single-clock queue that holds up to four 8-bit words. It is built for a consumer that wants to see the next word before it commits to taking it. The oldest stored word drives the output at all times. A read strobe does not fetch data. It only retires the word on show and moves the next one into view.

A producer offers a word by raising the write enable for one clock. The word is taken at the next rising edge if there was room before that edge. A consumer retires the head word by raising the read enable. Two status outputs report full and empty.

Acceptance depends only on the occupancy before the edge. A write offered to a full queue is lost, even if a read frees a slot on the same edge. While the queue is empty, the output keeps the last word it showed. Reset is synchronous and active high. It empties the queue but leaves the stored words in place.

Top module: `fwft_queue4`

## Requirements
- R1: The queue stores 8-bit words and holds exactly four of them. Four accepted writes into an empty queue make it full, and a fifth write is lost.
- R2: `is_full` is 1 exactly when four words are stored.
- R3: `is_empty` is 1 exactly when no word is stored.
- R4: When at least one word is stored, `head_word` shows the oldest unread word with no read strobe needed.
- R5: A write is accepted on a rising edge only when `push_en` is 1 and fewer than four words were stored before that edge.
- R6: A read is accepted on a rising edge only when `pop_en` is 1 and at least one word was stored before that edge. A read of an empty queue changes nothing.
- R7: When the queue is full and both enables are 1, the read is performed and the write is dropped, which leaves three words.
- R8: When the queue is empty and both enables are 1, only the write takes effect, and the new word is on `head_word` after that edge.
- R9: While `rst` is 1 at a rising edge, the queue becomes empty and `head_word` reads 0 after that edge.
- R10: While the queue is empty, `head_word` keeps the last word it showed, or 0 if it has shown no word since reset.
- R11: Words leave in the order they were accepted, including across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Offer `push_word` for storage at this edge |
| push_word | input | 8 | Word to store |
| pop_en | input | 1 | Retire the word on `head_word` at this edge |
| head_word | output | 8 | Oldest stored word, or the held last word when empty |
| is_full | output | 1 | Four words stored |
| is_empty | output | 1 | No word stored |

## Verification
The bench starts from every occupancy from zero to four and applies every combination of the two enables at that level. It then drains the queue and compares each word against an arithmetic model.

The full-with-both-enables case catches a design that decides acceptance after the read: such a design would store the write and stay full. The empty-with-both-enables case catches a design that reads a stale slot or lets the word pass through as if the queue were empty. Runs long enough to wrap the pointers several times expose pointer width or ordering errors as out-of-order words. Draining to empty and then resetting in the middle of a run shows whether the output holds its last word, or goes to an unread slot or to the new word too early.

// File: rtl/fwft_queue4.sv
module fwft_queue4 #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop_en,
  output logic [WIDTH-1:0] head_word,
  output logic             is_full,
  output logic             is_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    occ;
  logic [WIDTH-1:0] held;
  logic             take_in, take_out;

  assign is_full   = (occ == FULL_CNT);
  assign is_empty  = (occ == '0);
  assign take_in   = push_en && !is_full;
  assign take_out  = pop_en && !is_empty;
  assign head_word = is_empty ? held : slots[rd_ptr];

  always_ff @(posedge clk)
    if (take_in) slots[wr_ptr] <= push_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      held   <= '0;
    end else begin
      if (take_in)  wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (take_out) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (take_in && !take_out)      occ <= occ + 1'b1;
      else if (take_out && !take_in) occ <= occ - 1'b1;
      if (!is_empty) held <= slots[rd_ptr];
    end
  end
endmodule

// File: rtl/fwft_queue4_checker.sv
module fwft_queue4_checker (
  input logic       clk,
  input logic       rst,
  input logic       push_en,
  input logic [7:0] push_word,
  input logic       pop_en,
  input logic [7:0] head_word,
  input logic       is_full,
  input logic       is_empty
);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(is_full && is_empty));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    is_full && push_en && !pop_en |=> is_full && $stable(head_word));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    is_empty && !push_en |=> is_empty && $stable(head_word));

  assert_head_steady_R4: assert property (@(posedge clk) disable iff (rst)
    !is_empty && !pop_en |=> $stable(head_word));

  assert_full_both_R7: assert property (@(posedge clk) disable iff (rst)
    is_full && push_en && pop_en |=> !is_full && !is_empty);

  assert_empty_both_R8: assert property (@(posedge clk) disable iff (rst)
    is_empty && push_en |=> !is_empty && head_word == $past(push_word));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> is_empty && head_word == 8'h00);
endmodule

bind fwft_queue4 fwft_queue4_checker u_chk (
  .clk(clk), .rst(rst), .push_en(push_en), .push_word(push_word),
  .pop_en(pop_en), .head_word(head_word), .is_full(is_full), .is_empty(is_empty)
);

// File: tb/fwft_queue4_bench.sv
`timescale 1ns/1ps
module fwft_queue4_bench;
  logic       clk = 0, rst = 1, push_en = 0, pop_en = 0;
  logic [7:0] push_word = 0;
  logic [7:0] head_word;
  logic       is_full, is_empty;

  int vectors = 0, misses = 0;
  logic [7:0] q [4];
  int hd = 0, cnt = 0;
  logic [7:0] exp_hold = 0;
  logic [15:0] lfsr = 16'h1D2B;
  bit done = 0;

  fwft_queue4 u_fwft_queue4 (
    .clk(clk), .rst(rst), .push_en(push_en), .push_word(push_word),
    .pop_en(pop_en), .head_word(head_word), .is_full(is_full), .is_empty(is_empty)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string ctx);
    check({ctx, " R2 is_full"}, {7'd0, is_full}, {7'd0, cnt == 4});
    check({ctx, " R3 is_empty"}, {7'd0, is_empty}, {7'd0, cnt == 0});
    if (cnt > 0) begin
      check({ctx, " R4/R11 head"}, head_word, q[hd]);
      exp_hold = q[hd];
    end else begin
      check({ctx, " R10 held"}, head_word, exp_hold);
    end
  endtask

  task automatic step(input string ctx, input logic p, input logic r, input logic [7:0] d);
    bit ai, ao;
    int t;
    @(negedge clk);
    push_en = p; pop_en = r; push_word = d;
    #1;
    check_state(ctx);
    ai = p && cnt < 4;
    ao = r && cnt > 0;
    t = (hd + cnt) % 4;
    @(posedge clk);
    if (ai) q[t] = d;
    if (ao) hd = (hd + 1) % 4;
    cnt = cnt + int'(ai) - int'(ao);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; push_en = 0; pop_en = 0;
    @(posedge clk);
    cnt = 0; hd = 0; exp_hold = 0;
    @(negedge clk);
    rst = 0;
    #1;
    check("R9 empty after reset", {7'd0, is_empty}, 8'd1);
    check("R9 head after reset", head_word, 8'h00);
  endtask

  initial begin
    do_reset();
    for (int k = 0; k < 5; k++) step("R1 fill", 1, 0, 8'hA0 + 8'(k));
    check("R1 full after four", {7'd0, is_full}, 8'd1);
    for (int k = 0; k < 5; k++) step("R1 drain", 0, 1, 8'h00);
    step("R6 pop empty", 0, 1, 8'h00);

    for (int occ = 0; occ <= 4; occ++)
      for (int c = 0; c < 4; c++) begin
        string ctx;
        do_reset();
        for (int k = 0; k < occ; k++) step("R5 prefill", 1, 0, 8'(16 * occ + k + 1));
        if (occ == 4 && c == 3)      ctx = "R7 full both";
        else if (occ == 0 && c == 3) ctx = "R8 empty both";
        else if (c[0])               ctx = "R5 push";
        else                         ctx = "R6 pop";
        step(ctx, c[0], c[1], 8'hE0 + 8'(c));
        step(ctx, 0, 0, 8'h00);
        if (occ == 4 && c == 3)
          check("R7 three left", {7'd0, is_full}, 8'd0);
        for (int k = 0; k < 5; k++) step({ctx, " drain"}, 0, 1, 8'h00);
      end

    do_reset();
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n == 1500) do_reset();
      step("R11 random", lfsr[0], lfsr[3], lfsr[15:8]);
    end
    step("R11 final", 0, 0, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule